// File: doc/BRIEF.md
# Four-Phase Handshake Sequencer Ring

This block is a closed ring of handshake control stages that behaves as a self-timed micropipeline. It is modelled on a synchronous clock. A single token moves from stage to stage. Each link uses a four-phase request/acknowledge exchange. Every stage that takes the token raises a one-cycle activation strobe, and a processor step such as fetch, decode or execute hangs off that strobe. Between each pair of stages there is a delay element. It holds the request for a parameter-set number of clock ticks, which stands in for a matched delay. The link from the last stage back to the first has a delay element of its own.

Nothing moves until an external start request arrives. A rising edge on the start input, sampled while the ring is empty, places a token in the first stage. The token then laps the ring for as long as no stop is given. To stop the sequence, the control unit raises `halt`. The break takes effect when the returning request reaches the first stage. That stage then completes the handshake but neither fires nor forwards, so the ring drains and stays silent until the next start edge.

The parameters must give one full lap, `(NUM_STAGES-1)*(STAGE_TICKS+1) + FEEDBACK_TICKS+1` cycles, of at least `STAGE_TICKS+5` cycles. This leaves every link time to return to idle before the token comes back. `NUM_STAGES` must be at least 2.

Top module: `hs_sequencer_ring`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every strobe bit and `busy` are low. `rst` is synchronous and active high.
- R2: On every link the order is request rise, acknowledge rise, request fall, acknowledge fall. A request rises only while its acknowledge is low. An acknowledge rises only after the delayed request is high. A request falls only after its acknowledge is high. An acknowledge falls only after the delayed request has gone low.
- R3: When `start_req` is sampled high, was sampled low at the previous edge, and `busy` is low, `strobe[0]` is high for exactly the one cycle that follows that edge.
- R4: Strobes fire in rising index order. `strobe[k+1]` rises `STAGE_TICKS+1` cycles after `strobe[k]` rises. Each strobe lasts one cycle, and at most one strobe bit is high in any cycle.
- R5: Once started, the token circulates without further input. `strobe[0]` rises `FEEDBACK_TICKS+1` cycles after `strobe[NUM_STAGES-1]`.
- R6: Suppose `halt` is high at the edge where the returning request would fire `strobe[0]`. Then that strobe does not fire, and no strobe fires afterwards until a new start edge.
- R7: A high `halt` at any other edge has no effect on the strobe sequence.
- R8: `busy` is high in every cycle in which a strobe is high and while a token is in the ring. It falls exactly three cycles after the edge at which the token was absorbed.
- R9: A start edge seen while `busy` is high, including during the drain after a stop, is ignored and does not create a second token.
- R10: After the ring has drained, a new start edge restarts the sequence at stage 0. The start is taken even if `halt` is high at that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that times the handshake and the delay counters |
| rst | input | 1 | Synchronous active-high reset; clears all request and acknowledge lines |
| start_req | input | 1 | External request; its rising edge launches a token when the ring is idle |
| halt | input | 1 | Ring break from the control unit; absorbs the token on its return to stage 0 |
| strobe | output | NUM_STAGES | One-cycle activation strobe per stage |
| busy | output | 1 | High while any stage holds a request or acknowledge |

## Verification
The reference model is run against a single start from idle. This shows whether the first strobe lands on the edge that samples the start and whether stage-to-stage spacing and the longer feedback hop are exact. The model is also run against repeated start pulses during circulation and during the post-stop drain, which separates a correct design from one that launches a second token. Single-cycle `halt` pulses timed away from the token's return are contrasted with a `halt` held across the return. This distinguishes a break that acts only at the first stage from one that acts anywhere, and it also times the fall of `busy`. A final restart with `halt` already high confirms that the start edge is taken and that exactly one lap follows.

// File: rtl/hs_ring_pkg.sv
package hs_ring_pkg;

    // Registered state of one control stage.
    typedef struct packed {
        logic req;   // request toward the downstream delay element
        logic ack;   // acknowledge toward the upstream stage
        logic fire;  // one-cycle activation strobe
    } hs_stage_t;

    // Cycles between a stage's strobe and the next one: delay ticks plus
    // the register of the receiving stage.
    localparam int unsigned STAGE_REG_CYCLES = 1;

    // Cycles from absorbing the token until every link is back at idle.
    localparam int unsigned DRAIN_CYCLES = 3;

    function automatic int unsigned hop_cycles(input int unsigned ticks);
        return ticks + STAGE_REG_CYCLES;
    endfunction

    function automatic int unsigned lap_cycles(input int unsigned stages,
                                               input int unsigned ticks,
                                               input int unsigned fb_ticks);
        return (stages - 1) * hop_cycles(ticks) + hop_cycles(fb_ticks);
    endfunction

    function automatic int unsigned count_width(input int unsigned ticks);
        return (ticks < 2) ? 1 : $clog2(ticks);
    endfunction

endpackage

// File: rtl/hs_delay.sv
module hs_delay
    import hs_ring_pkg::*;
#(
    parameter int unsigned TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic a_i,
    output logic y_o
);
    localparam int unsigned CW = count_width(TICKS);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          y_q;

    // Rising request is held TICKS cycles; falling request passes in one.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            y_q   <= 1'b0;
        end else if (!a_i) begin
            cnt_q <= '0;
            y_q   <= 1'b0;
        end else if (!y_q) begin
            if (cnt_q == LAST) begin
                y_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign y_o = y_q;

endmodule

// File: rtl/hs_stage.sv
module hs_stage
    import hs_ring_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic up_req_i,
    output logic up_ack_o,
    output logic dn_req_o,
    input  logic dn_ack_i,
    input  logic inject_i,
    input  logic sink_i,
    output logic fire_o
);
    hs_stage_t st_q;
    logic      free_w;
    logic      take_w;

    // A stage is free once both of its links have returned to zero.
    assign free_w = !st_q.req && !st_q.ack && !dn_ack_i;
    assign take_w = free_w && up_req_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.fire <= 1'b0;
            if (take_w) begin
                st_q.ack <= 1'b1;
                if (!sink_i) begin
                    st_q.req  <= 1'b1;
                    st_q.fire <= 1'b1;
                end
            end else if (inject_i && free_w) begin
                st_q.req  <= 1'b1;
                st_q.fire <= 1'b1;
            end
            if (st_q.ack && !up_req_i) begin
                st_q.ack <= 1'b0;
            end
            if (st_q.req && dn_ack_i) begin
                st_q.req <= 1'b0;
            end
        end
    end

    assign up_ack_o = st_q.ack;
    assign dn_req_o = st_q.req;
    assign fire_o   = st_q.fire;

endmodule

// File: rtl/hs_ring_ctl.sv
module hs_ring_ctl #(
    parameter int unsigned NUM_STAGES = 33
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_req,
    input  logic                  halt,
    input  logic [NUM_STAGES-1:0] hold_vec,
    output logic                  inject,
    output logic                  sink,
    output logic                  busy
);
    logic start_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_prev_q <= 1'b0;
        end else begin
            start_prev_q <= start_req;
        end
    end

    assign busy   = |hold_vec;
    assign inject = start_req && !start_prev_q && !busy;
    assign sink   = halt;

endmodule

// File: rtl/hs_sequencer_ring.sv
module hs_sequencer_ring
    import hs_ring_pkg::*;
#(
    parameter int unsigned NUM_STAGES     = 33,
    parameter int unsigned STAGE_TICKS    = 2,
    parameter int unsigned FEEDBACK_TICKS = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_req,
    input  logic                  halt,
    output logic [NUM_STAGES-1:0] strobe,
    output logic                  busy
);
    logic [NUM_STAGES-1:0] st_req;
    logic [NUM_STAGES-1:0] st_ack;
    logic [NUM_STAGES-1:0] st_fire;
    logic [NUM_STAGES-1:0] dly_y;
    logic [NUM_STAGES-1:0] hold_vec;
    logic [NUM_STAGES-1:0] inj_vec;
    logic [NUM_STAGES-1:0] sink_vec;
    logic                  inject;
    logic                  sink;

    assign hold_vec = st_req | st_ack;
    assign inj_vec  = NUM_STAGES'(inject);
    assign sink_vec = NUM_STAGES'(sink);

    hs_ring_ctl #(.NUM_STAGES(NUM_STAGES)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .start_req(start_req),
        .halt     (halt),
        .hold_vec (hold_vec),
        .inject   (inject),
        .sink     (sink),
        .busy     (busy)
    );

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        localparam int PREV = (k == 0) ? NUM_STAGES - 1 : k - 1;
        localparam int NEXT = (k == NUM_STAGES - 1) ? 0 : k + 1;
        localparam int unsigned TK =
            (k == NUM_STAGES - 1) ? FEEDBACK_TICKS : STAGE_TICKS;

        hs_stage u_stage (
            .clk     (clk),
            .rst     (rst),
            .up_req_i(dly_y[PREV]),
            .up_ack_o(st_ack[k]),
            .dn_req_o(st_req[k]),
            .dn_ack_i(st_ack[NEXT]),
            .inject_i(inj_vec[k]),
            .sink_i  (sink_vec[k]),
            .fire_o  (st_fire[k])
        );

        hs_delay #(.TICKS(TK)) u_delay (
            .clk(clk),
            .rst(rst),
            .a_i(st_req[k]),
            .y_o(dly_y[k])
        );
    end

    assign strobe = st_fire;

endmodule

// File: rtl/hs_ring_checker.sv
module hs_ring_checker #(
    parameter int unsigned N = 33
) (
    input logic         clk,
    input logic         rst,
    input logic         start_req,
    input logic         halt,
    input logic [N-1:0] strobe,
    input logic         busy,
    input logic [N-1:0] lreq,
    input logic [N-1:0] dy,
    input logic [N-1:0] stack
);
    // R1: idle right after reset release
    a_r1_idle_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (!busy && strobe == '0));

    for (genvar k = 0; k < N; k++) begin : g_link
        localparam int NX = (k == N - 1) ? 0 : k + 1;

        // R2: request rises only on an idle link
        a_r2_req_rise_idle: assert property (@(posedge clk) disable iff (rst)
            $rose(lreq[k]) |-> $past(!stack[NX]));
        // R2: delayed request appears only behind a live request
        a_r2_delay_follows_req: assert property (@(posedge clk) disable iff (rst)
            $rose(dy[k]) |-> $past(lreq[k]));
        // R2: acknowledge rises only after the delayed request
        a_r2_ack_after_req: assert property (@(posedge clk) disable iff (rst)
            $rose(stack[NX]) |-> $past(dy[k]));
        // R2: request falls only after acknowledge
        a_r2_req_fall_after_ack: assert property (@(posedge clk) disable iff (rst)
            $fell(lreq[k]) |-> $past(stack[NX]));
        // R2: acknowledge falls only after the request is gone
        a_r2_ack_fall_after_release: assert property (@(posedge clk) disable iff (rst)
            $fell(stack[NX]) |-> $past(!dy[k]));
    end

    // R4: a single token, so at most one strobe per cycle
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe));

    // R3 and R5: stage 0 fires only from a start or from the feedback link
    a_r5_head_source: assert property (@(posedge clk) disable iff (rst)
        strobe[0] |-> ($past(dy[N-1]) || $past(start_req)));

    // R6: a returning token seen with halt high never fires stage 0
    a_r6_break_absorbs: assert property (@(posedge clk) disable iff (rst)
        (strobe[0] && $past(dy[N-1])) |-> !$past(halt));

    // R8: any strobe implies busy
    a_r8_busy_covers_strobe: assert property (@(posedge clk) disable iff (rst)
        (strobe != '0) |-> busy);

    // R9: while busy, stage 0 fires only from the feedback link
    a_r9_no_second_token: assert property (@(posedge clk) disable iff (rst)
        (strobe[0] && $past(busy)) |-> $past(dy[N-1]));

endmodule

bind hs_sequencer_ring hs_ring_checker #(.N(NUM_STAGES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_req(start_req),
    .halt     (halt),
    .strobe   (strobe),
    .busy     (busy),
    .lreq     (st_req),
    .dy       (dly_y),
    .stack    (st_ack)
);

// File: tb/sim_hs_sequencer_ring.sv
module sim_hs_sequencer_ring;
    localparam int N  = 6;
    localparam int D  = 2;
    localparam int FB = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_req = 1'b0;
    logic         halt = 1'b0;
    logic [N-1:0] strobe;
    logic         busy;

    int    vectors = 0;
    int    fails   = 0;
    bit    done    = 1'b0;
    string cur_tag = "R1";

    // Reference model state
    bit           m_tok = 1'b0;
    bit           m_sp  = 1'b0;
    int           m_next = 0;
    int           m_wait = 0;
    int           m_drain = 0;
    logic [N-1:0] m_strobe = '0;
    logic         m_busy = 1'b0;

    hs_sequencer_ring #(
        .NUM_STAGES(N), .STAGE_TICKS(D), .FEEDBACK_TICKS(FB)
    ) u0 (
        .clk(clk), .rst(rst), .start_req(start_req), .halt(halt),
        .strobe(strobe), .busy(busy)
    );

    always #2 clk = ~clk;

    task automatic model_update();
        bit busy_before;
        busy_before = m_tok || (m_drain > 0);
        m_strobe = '0;
        if (rst) begin
            m_tok = 1'b0; m_sp = 1'b0; m_next = 0; m_wait = 0; m_drain = 0;
        end else begin
            if (m_tok) begin
                m_wait--;
                if (m_wait == 0) begin
                    if (m_next == 0 && halt) begin
                        m_tok   = 1'b0;   // R6: absorbed at stage 0
                        m_drain = 3;      // R8: busy falls three cycles later
                    end else begin
                        m_strobe[m_next] = 1'b1;
                        m_wait = (m_next == N - 1) ? FB + 1 : D + 1;
                        m_next = (m_next + 1) % N;
                    end
                end
            end else if (m_drain > 0) begin
                m_drain--;
            end
            if (start_req && !m_sp && !busy_before) begin
                m_strobe[0] = 1'b1;
                m_tok  = 1'b1;
                m_next = 1;
                m_wait = D + 1;
            end
            m_sp = start_req;
        end
        m_busy = m_tok || (m_drain > 0);
    endtask

    task automatic compare();
        vectors++;
        if (strobe !== m_strobe || busy !== m_busy) begin
            fails++;
            $display("FAIL %s: strobe=%b busy=%b expected strobe=%b busy=%b",
                     cur_tag, strobe, busy, m_strobe, m_busy);
        end
    endtask

    task automatic tick(input logic s, input logic h);
        start_req = s;
        halt      = h;
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        cur_tag = "R1";
        rst = 1'b1;
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b0);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b0);

        // R3 R4 R5: launch and free circulation over several laps
        cur_tag = "R3 R4 R5";
        tick(1'b1, 1'b0);
        for (int i = 0; i < 55; i++) tick(1'b0, 1'b0);

        // R9: repeated start edges while circulating
        cur_tag = "R9";
        for (int i = 0; i < 40; i++) tick(i % 4 == 1, 1'b0);

        // R7: short halt pulses away from the token's return
        cur_tag = "R7";
        for (int i = 0; i < 45; i++) begin
            bit h;
            h = (i % 3 == 0) && !(m_tok && m_next == 0 && m_wait == 1);
            tick(1'b0, h);
        end

        // R6 R8: hold halt across the return, then watch the drain
        cur_tag = "R6 R8";
        for (int i = 0; i < 40 && m_tok; i++) tick(1'b0, 1'b1);
        // R9: start edge during the drain must be ignored
        cur_tag = "R9 R8";
        tick(1'b1, 1'b0);
        for (int i = 0; i < 30; i++) tick(1'b0, 1'b0);

        // R10: restart after drain with halt already high -> one lap only
        cur_tag = "R10 R6";
        tick(1'b1, 1'b1);
        for (int i = 0; i < 40; i++) tick(1'b0, 1'b1);
        halt = 1'b0;

        // R10 R5: plain restart, free laps again
        cur_tag = "R10 R5";
        tick(1'b1, 1'b0);
        for (int i = 0; i < 45; i++) tick(1'b0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule